// File: doc/BRIEF.md
# Flag-Producing Word ALU

This block is the purely combinational execute stage of a small load/store machine whose datapath word is `W` bits wide. Each cycle it receives an operation code, two operand words and the present value of the machine's single condition flag. It returns a result word, a strobe saying whether that word should be written to the destination register, and the next value of the flag.

The flag does not have one shared meaning. It depends on the operation class:

- **Shifts** report a bit taken from the end of the source word.
- **Arithmetic** reports overflow, carry, borrow or a zero divisor.
- **Bitwise operations** report a zero result.
- **Comparisons** write the flag and nothing else.

Operation codes that the unit does not define leave both the register file and the flag alone.

Register file, decode, operand fetch and memory sit outside the block. The surrounding pipeline routes an immediate or a register value into the second operand before the call.

Top module: `wordalu`

## Requirements
- R1: Codes 0 (and), 1 (or), 2 (xor) and 3 (not of operand B) each assert `wr_en` and return the bitwise result. `flag_next` is 1 exactly when that result word is all zeros.
- R2: Code 11 (shift left) returns A shifted left by B, read as unsigned, with zero fill. It returns all zeros when B is W or more. `flag_next` equals bit W-1 of the unshifted A, and `wr_en` is 1.
- R3: Code 12 (shift right) returns A shifted right by unsigned B with zero fill. It returns all zeros when B is W or more. `flag_next` equals bit 0 of the unshifted A, and `wr_en` is 1.
- R4: Code 4 (add) returns (A+B) mod 2^W. `flag_next` is the carry out of bit W-1, and `wr_en` is 1.
- R5: Code 5 (subtract) returns (A-B) mod 2^W. `flag_next` is 1 exactly when B is greater than A as unsigned numbers (a borrow), and `wr_en` is 1.
- R6: Code 6 (low multiply) returns the low W bits of the unsigned product. Code 7 (unsigned high multiply) returns its upper W bits. For both, `flag_next` is 1 exactly when that upper half is nonzero, and `wr_en` is 1.
- R7: Code 8 (signed high multiply) returns the upper W bits of the two's-complement product. `flag_next` is 1 exactly when the product does not fit in W signed bits, and `wr_en` is 1.
- R8: With a nonzero B, code 9 returns the quotient q and code 10 the remainder r of unsigned division. These satisfy A = q·B + r and r < B. `flag_next` is 0 and `wr_en` is 1.
- R9: Code 9 or 10 with B equal to zero returns a result of 0 with `flag_next` = 1 and `wr_en` = 1.
- R10: Comparisons drive `wr_en` = 0 and `result` = 0. `flag_next` is set as follows:
  - code 13: A equal B
  - code 14: A above B, unsigned
  - code 15: A above or equal B, unsigned
  - code 16: A greater than B, signed
  - code 17: A greater than or equal B, signed
- R11: Codes 18 to 31 drive `wr_en` = 0 and `result` = 0, and pass `flag_cur` to `flag_next` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 5 | Operation code |
| opnd_a | input | W | First operand (source word) |
| opnd_b | input | W | Second operand (register or immediate value) |
| flag_cur | input | 1 | Present condition flag |
| result | output | W | Result word |
| wr_en | output | 1 | Destination register write strobe |
| flag_next | output | 1 | Next condition flag |

## Verification
The bench builds the unit with W = 16. At that width the full double-width product and every quotient fit in a 64-bit integer, so a plain behavioural model can compute each expected value exactly. The narrow word also lets a short operand set land on every edge:

- shift amounts just below, at and above the word width;
- the most negative signed value;
- products that just fit or just overflow in signed form;
- divisors of zero and one.

Each of these is applied under every one of the 32 operation codes, together with random operands.

// File: rtl/wordalu_pkg.sv
package wordalu_pkg;

    typedef enum logic [4:0] {
        OP_AND   = 5'd0,
        OP_OR    = 5'd1,
        OP_XOR   = 5'd2,
        OP_NOT   = 5'd3,
        OP_ADD   = 5'd4,
        OP_SUB   = 5'd5,
        OP_MULL  = 5'd6,
        OP_UMULH = 5'd7,
        OP_SMULH = 5'd8,
        OP_UDIV  = 5'd9,
        OP_UMOD  = 5'd10,
        OP_SHL   = 5'd11,
        OP_SHR   = 5'd12,
        OP_CMPE  = 5'd13,
        OP_CMPA  = 5'd14,
        OP_CMPAE = 5'd15,
        OP_CMPG  = 5'd16,
        OP_CMPGE = 5'd17
    } alu_op_e;

    typedef enum logic [2:0] {
        GRP_LOGIC,
        GRP_ARITH,
        GRP_DIV,
        GRP_CMP,
        GRP_NONE
    } alu_grp_e;

    typedef struct packed {
        alu_grp_e grp;
        logic     writes;
    } op_info_t;

    function automatic op_info_t classify(input logic [4:0] code);
        op_info_t info;
        info.writes = 1'b1;
        if (code <= 5'd3 || code == 5'd11 || code == 5'd12) begin
            info.grp = GRP_LOGIC;
        end else if (code <= 5'd8) begin
            info.grp = GRP_ARITH;
        end else if (code <= 5'd10) begin
            info.grp = GRP_DIV;
        end else if (code <= 5'd17) begin
            info.grp    = GRP_CMP;
            info.writes = 1'b0;
        end else begin
            info.grp    = GRP_NONE;
            info.writes = 1'b0;
        end
        return info;
    endfunction

endpackage

// File: rtl/wordalu_logic.sv
module wordalu_logic
    import wordalu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [4:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         flag
);
    localparam int SHW = (W > 1) ? $clog2(W) : 1;
    localparam logic [W-1:0] WIDTH_WORD = W'(W);

    logic oversize;
    assign oversize = (b >= WIDTH_WORD);

    always_comb begin
        res  = '0;
        flag = 1'b0;
        case (alu_op_e'(op))
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_NOT: res = ~b;
            OP_SHL: begin
                res  = oversize ? '0 : (a << b[SHW-1:0]);
                flag = a[W-1];
            end
            OP_SHR: begin
                res  = oversize ? '0 : (a >> b[SHW-1:0]);
                flag = a[0];
            end
            default: res = '0;
        endcase
        if (op <= 5'd3) begin
            flag = (res == '0);
        end
    end
endmodule

// File: rtl/wordalu_arith.sv
module wordalu_arith
    import wordalu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [4:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         flag
);
    logic [W:0]            sum;
    logic [W:0]            diff;
    logic [2*W-1:0]        uprod;
    logic signed [2*W-1:0] sprod;

    assign sum   = {1'b0, a} + {1'b0, b};
    // a + 2^W - b: bit W stays set unless a borrow consumed it
    assign diff  = {1'b1, a} - {1'b0, b};
    assign uprod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    assign sprod = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});

    always_comb begin
        res  = '0;
        flag = 1'b0;
        case (alu_op_e'(op))
            OP_ADD: begin
                res  = sum[W-1:0];
                flag = sum[W];
            end
            OP_SUB: begin
                res  = diff[W-1:0];
                flag = ~diff[W];
            end
            OP_MULL: begin
                res  = uprod[W-1:0];
                flag = |uprod[2*W-1:W];
            end
            OP_UMULH: begin
                res  = uprod[2*W-1:W];
                flag = |uprod[2*W-1:W];
            end
            OP_SMULH: begin
                res  = sprod[2*W-1:W];
                flag = (sprod[2*W-1:W] != {W{sprod[W-1]}});
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/wordalu_divider.sv
module wordalu_divider #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    logic [W-1:0] part [W+1];

    assign part[0] = '0;

    for (genvar i = 0; i < W; i++) begin : g_stage
        logic [W:0] trial;
        logic [W:0] less;
        logic       fits;
        assign trial = {part[i], a[W-1-i]};
        assign less  = trial - {1'b0, b};
        assign fits  = (trial >= {1'b0, b});
        assign part[i+1]  = fits ? less[W-1:0] : trial[W-1:0];
        assign quo[W-1-i] = fits;
    end

    assign rem = part[W];
endmodule

// File: rtl/wordalu_compare.sv
module wordalu_compare
    import wordalu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [4:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         flag
);
    logic eq;
    logic ugt;
    logic sgt;

    assign eq  = (a == b);
    assign ugt = (a > b);
    assign sgt = ($signed(a) > $signed(b));

    always_comb begin
        case (alu_op_e'(op))
            OP_CMPE:  flag = eq;
            OP_CMPA:  flag = ugt;
            OP_CMPAE: flag = ugt | eq;
            OP_CMPG:  flag = sgt;
            OP_CMPGE: flag = sgt | eq;
            default:  flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/wordalu.sv
module wordalu
    import wordalu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [4:0]   op,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         flag_cur,
    output logic [W-1:0] result,
    output logic         wr_en,
    output logic         flag_next
);
    op_info_t     info;
    logic [W-1:0] lg_res;
    logic         lg_flag;
    logic [W-1:0] ar_res;
    logic         ar_flag;
    logic [W-1:0] dv_quo;
    logic [W-1:0] dv_rem;
    logic         cmp_flag;
    logic         zero_div;

    assign info     = classify(op);
    assign zero_div = (opnd_b == '0);

    wordalu_logic #(.W(W)) u_logic (
        .op(op), .a(opnd_a), .b(opnd_b), .res(lg_res), .flag(lg_flag)
    );

    wordalu_arith #(.W(W)) u_arith (
        .op(op), .a(opnd_a), .b(opnd_b), .res(ar_res), .flag(ar_flag)
    );

    wordalu_divider #(.W(W)) u_div (
        .a(opnd_a), .b(opnd_b), .quo(dv_quo), .rem(dv_rem)
    );

    wordalu_compare #(.W(W)) u_cmp (
        .op(op), .a(opnd_a), .b(opnd_b), .flag(cmp_flag)
    );

    always_comb begin
        result    = '0;
        flag_next = flag_cur;
        wr_en     = info.writes;
        case (info.grp)
            GRP_LOGIC: begin
                result    = lg_res;
                flag_next = lg_flag;
            end
            GRP_ARITH: begin
                result    = ar_res;
                flag_next = ar_flag;
            end
            GRP_DIV: begin
                if (zero_div) begin
                    result    = '0;
                    flag_next = 1'b1;
                end else begin
                    result    = (alu_op_e'(op) == OP_UDIV) ? dv_quo : dv_rem;
                    flag_next = 1'b0;
                end
            end
            GRP_CMP: flag_next = cmp_flag;
            default: flag_next = flag_cur;
        endcase
    end
endmodule

// File: rtl/wordalu_checker.sv
module wordalu_checker #(
    parameter int W = 32
) (
    input logic [4:0]   op,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic         flag_cur,
    input logic [W-1:0] result,
    input logic         wr_en,
    input logic         flag_next
);
    logic [2*W-1:0] qb;

    always_comb begin
        qb = (2*W)'(result) * (2*W)'(opnd_b);
        if (op <= 5'd3) begin
            AST_BITWISE_ZERO_FLAG: assert (flag_next == (result == '0) && wr_en); // R1
        end
        if (op == 5'd11) begin
            AST_SHL_TOP_BIT: assert (flag_next == opnd_a[W-1] && wr_en); // R2
        end
        if (op == 5'd12) begin
            AST_SHR_LOW_BIT: assert (flag_next == opnd_a[0] && wr_en); // R3
        end
        if (op == 5'd9 && opnd_b != '0) begin
            AST_QUOTIENT_BOUNDS: assert (qb <= (2*W)'(opnd_a)
                && ((2*W)'(opnd_a) - qb) < (2*W)'(opnd_b) && !flag_next); // R8
        end
        if (op == 5'd10 && opnd_b != '0) begin
            AST_REMAINDER_BELOW: assert (result < opnd_b && !flag_next); // R8
        end
        if ((op == 5'd9 || op == 5'd10) && opnd_b == '0) begin
            AST_DIV_ZERO: assert (result == '0 && flag_next && wr_en); // R9
        end
        if (op >= 5'd13 && op <= 5'd17) begin
            AST_CMP_NO_WRITE: assert (!wr_en && result == '0); // R10
        end
        if (op >= 5'd18) begin
            AST_IDLE_FLAG_KEPT: assert (!wr_en && result == '0 && flag_next == flag_cur); // R11
        end
    end
endmodule

bind wordalu wordalu_checker #(.W(W)) u_chk (
    .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b), .flag_cur(flag_cur),
    .result(result), .wr_en(wr_en), .flag_next(flag_next)
);

// File: tb/tb_wordalu.sv
module tb_wordalu;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [4:0]   op = '0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         fc = 1'b0;
    logic [W-1:0] result;
    logic         wr_en;
    logic         flag_next;
    int           n_cmp = 0;
    int           n_bad = 0;
    bit           done = 1'b0;

    always #5ns clk = ~clk;

    wordalu #(.W(W)) dut (
        .op(op), .opnd_a(a), .opnd_b(b), .flag_cur(fc),
        .result(result), .wr_en(wr_en), .flag_next(flag_next)
    );

    function automatic string rtag(input int code, input logic [W-1:0] bv);
        if (code <= 3) return "R1";
        if (code == 11) return "R2";
        if (code == 12) return "R3";
        if (code == 4) return "R4";
        if (code == 5) return "R5";
        if (code == 6 || code == 7) return "R6";
        if (code == 8) return "R7";
        if ((code == 9 || code == 10) && bv == 0) return "R9";
        if (code == 9 || code == 10) return "R8";
        if (code <= 17) return "R10";
        return "R11";
    endfunction

    task automatic model(input int code, input logic [W-1:0] av, input logic [W-1:0] bv,
                         input logic fin, output logic [W-1:0] r, output logic w,
                         output logic f);
        longint unsigned ua = longint'(av);
        longint unsigned ub = longint'(bv);
        logic [63:0] p;
        longint sa = longint'($signed(av));
        longint sb = longint'($signed(bv));
        longint sp;
        r = '0; w = 1'b1; f = fin;
        case (code)
            0: r = av & bv;
            1: r = av | bv;
            2: r = av ^ bv;
            3: r = ~bv;
            default: ;
        endcase
        if (code <= 3) f = (r == 0);
        case (code)
            4: begin p = ua + ub; r = p[W-1:0]; f = (p >= 64'd65536); end
            5: begin r = av - bv; f = (ub > ua); end
            6: begin p = ua * ub; r = p[W-1:0]; f = (p[31:16] != 0); end
            7: begin p = ua * ub; r = p[31:16]; f = (p[31:16] != 0); end
            8: begin
                sp = sa * sb; p = sp; r = p[31:16];
                f = (sp < -32768) || (sp > 32767);
            end
            9:  begin if (ub == 0) begin r = 0; f = 1; end else begin r = W'(ua / ub); f = 0; end end
            10: begin if (ub == 0) begin r = 0; f = 1; end else begin r = W'(ua % ub); f = 0; end end
            11: begin r = (ub >= W) ? '0 : W'(ua << ub); f = av[W-1]; end
            12: begin r = (ub >= W) ? '0 : W'(ua >> ub); f = av[0]; end
            13: begin w = 0; f = (ua == ub); end
            14: begin w = 0; f = (ua > ub); end
            15: begin w = 0; f = (ua >= ub); end
            16: begin w = 0; f = (sa > sb); end
            17: begin w = 0; f = (sa >= sb); end
            default: if (code >= 18) begin w = 0; f = fin; end
        endcase
    endtask

    task automatic check_now(input string tag);
        logic [W-1:0] er;
        logic ew;
        logic ef;
        model(int'(op), a, b, fc, er, ew, ef);
        n_cmp++;
        if (result !== er || wr_en !== ew || flag_next !== ef) begin
            n_bad++;
            $display("FAIL %s op=%0d a=%h b=%h: got r=%h w=%b f=%b, expected r=%h w=%b f=%b",
                     tag, op, a, b, result, wr_en, flag_next, er, ew, ef);
        end
    endtask

    task automatic apply(input int code, input logic [W-1:0] av, input logic [W-1:0] bv,
                         input logic fin);
        @(posedge clk);
        #1ns;
        op = 5'(code); a = av; b = bv; fc = fin;
        @(negedge clk);
        check_now(rtag(code, bv));
    endtask

    logic [W-1:0] edges [10] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000, 16'h7FFF,
                                 16'd15, 16'd16, 16'd17, 16'h00FF, 16'h0100};

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset-time inputs are all zero: AND of zeros gives 0 with flag set
        check_now("R1");
        rst = 1'b0;
        for (int code = 0; code < 32; code++) begin
            for (int i = 0; i < 10; i++) begin
                for (int j = 0; j < 10; j++) begin
                    apply(code, edges[i], edges[j], 1'((i + j + code) & 1));
                end
            end
            for (int k = 0; k < 150; k++) begin
                apply(code, W'($urandom), W'($urandom), 1'($urandom));
            end
        end
        // R7: products at the signed boundary
        apply(8, 16'h0100, 16'h0080, 1'b0);
        apply(8, 16'hFF00, 16'h0080, 1'b0);
        apply(8, 16'h8000, 16'hFFFF, 1'b0);
        // R8: divisor of one and divisor above dividend
        apply(9, 16'h1234, 16'h0001, 1'b1);
        apply(10, 16'h0005, 16'h0009, 1'b1);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1ms;
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule